// File: doc/BRIEF.md
# Latched Address Decoder and Demultiplexer

This block turns a 4-bit binary address into one of sixteen active-high select lines. An address holding register sits in front of the decode and is controlled by a latch-enable input. While latch-enable is high, the register follows the address on each clock, and the decode uses the live address input directly. While latch-enable is low, the register keeps the address it last captured, so the select lines ignore any later address activity.

An active-low output enable gates all sixteen lines after the decode and never touches the held address. Because of this, the block also works as a 1-to-16 demultiplexer. A serial data bit is driven onto the enable pin and the address steers it. The chosen line then carries the inverse of the enable level, and every other line stays low. The output path is combinational from the enable, the address and the held value. The address width and the decode structure are parameters.

Top module: `latched_line_decoder`

## Requirements
- R1: The address is binary weighted with bit 0 as the least significant bit. With the enable active, line number `addr[0] + 2*addr[1] + 4*addr[2] + 8*addr[3]` of `sel_out` is the line driven high.
- R2: No more than one bit of `sel_out` is high in any cycle.
- R3: While `latch_en` is 1, `sel_out` decodes the current `addr` in the same cycle, with no register delay.
- R4: While `latch_en` is 0, the decode uses the address sampled at the last rising clock edge at which `latch_en` was 1. Changes on `addr` have no effect on `sel_out`.
- R5: When `en_n` is 0, the line indexed by the effective address (live or held) is 1.
- R6: When `en_n` is 1, all bits of `sel_out` are 0, whatever the address and latch state.
- R7: `en_n` has no effect on the held address. After any activity on `en_n` while `latch_en` is 0, re-enabling shows the same line as before.
- R8: Used as a demultiplexer with a fixed address, the addressed line equals the inverse of `en_n` in every cycle, and all other lines are 0.
- R9: A synchronous active-high `rst` clears the held address to 0. After reset with `latch_en` at 0 and `en_n` at 0, `sel_out` equals 16'h0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address holding register |
| rst | input | 1 | Synchronous active-high reset; clears the held address |
| latch_en | input | 1 | 1: pass the address through and capture it; 0: hold the stored address |
| en_n | input | 1 | Active-low output enable; acts as the data input in demultiplexer use |
| addr | input | 4 | Binary address, bit 0 least significant |
| sel_out | output | 16 | One-hot or all-zero active-high select lines |

## Verification
Two functions can land in the same cycle: the address capture at a clock edge and the output gating by `en_n`. The bench provokes this by changing `en_n` in the same cycle that `latch_en` falls or rises, and by moving `addr` while the outputs are gated off. The result is judged after the enable returns: the line shown must be the one predicted from the last edge at which `latch_en` was high, and `en_n` must have had no influence on it. Every sample is also checked for the one-hot-or-zero pattern.

// File: rtl/lld_pkg.sv
package lld_pkg;
   typedef enum logic [0:0] {
      DEC_COMPARE = 1'b0,
      DEC_SHIFT   = 1'b1
   } dec_style_e;

   function automatic int unsigned lines_for(input int unsigned aw);
      return 32'd1 << aw;
   endfunction
endpackage

// File: rtl/lld_addr_hold.sv
module lld_addr_hold #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              latch_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] eff_addr
);
   logic [ADDR_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst)
         hold_q <= '0;
      else if (latch_en)
         hold_q <= addr;
   end

   assign eff_addr = latch_en ? addr : hold_q;

   assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (!latch_en && !$past(latch_en) && !$past(rst)) |-> (hold_q == $past(hold_q)));

   assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (hold_q == '0));
endmodule

// File: rtl/lld_decode.sv
module lld_decode
   import lld_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter dec_style_e  STYLE  = DEC_COMPARE,
   localparam int unsigned LINES = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] sel_addr,
   output logic [LINES-1:0]  onehot
);
   generate
      if (STYLE == DEC_COMPARE) begin : g_cmp
         for (genvar i = 0; i < LINES; i++) begin : g_line
            assign onehot[i] = (sel_addr == ADDR_W'(i));
         end
      end else begin : g_shift
         assign onehot = LINES'(1) << sel_addr;
      end
   endgenerate

   always_comb begin
      assert_decode_onehot_R1: assert ($onehot(onehot) || $isunknown(sel_addr));
   end
endmodule

// File: rtl/lld_out_gate.sv
module lld_out_gate #(
   parameter int unsigned LINES = 16
) (
   input  logic             en_n,
   input  logic [LINES-1:0] lines_in,
   output logic [LINES-1:0] lines_out
);
   generate
      for (genvar i = 0; i < LINES; i++) begin : g_gate
         assign lines_out[i] = lines_in[i] & ~en_n;
      end
   endgenerate
endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder
   import lld_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter dec_style_e  STYLE  = DEC_COMPARE,
   localparam int unsigned LINES = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              latch_en,
   input  logic              en_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [LINES-1:0]  sel_out
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_width
         $error("latched_line_decoder: ADDR_W must lie in 1..8");
      end
      if (LINES != lines_for(ADDR_W)) begin : g_bad_lines
         $error("latched_line_decoder: line count mismatch");
      end
   endgenerate

   logic [ADDR_W-1:0] eff_addr;
   logic [LINES-1:0]  decoded;

   lld_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk(clk), .rst(rst), .latch_en(latch_en), .addr(addr), .eff_addr(eff_addr)
   );

   lld_decode #(.ADDR_W(ADDR_W), .STYLE(STYLE)) u_dec (
      .sel_addr(eff_addr), .onehot(decoded)
   );

   lld_out_gate #(.LINES(LINES)) u_gate (
      .en_n(en_n), .lines_in(decoded), .lines_out(sel_out)
   );

   assert_onehot0_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_out));

   assert_gated_off_R6: assert property (@(posedge clk) disable iff (rst)
      en_n |-> (sel_out == '0));

   assert_follow_live_R3: assert property (@(posedge clk) disable iff (rst)
      (latch_en && !en_n) |-> sel_out[addr]);

   assert_out_frozen_R4: assert property (@(posedge clk) disable iff (rst)
      (!latch_en && !$past(latch_en) && !en_n && !$past(en_n) && !$past(rst))
         |-> $stable(sel_out));
endmodule

// File: tb/latched_line_decoder_bench.sv
module latched_line_decoder_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        latch_en = 1'b0;
   logic        en_n = 1'b1;
   logic [3:0]  addr = 4'h0;
   logic [15:0] sel_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [3:0] model_hold = 4'h0;

   always #5 clk = ~clk;

   latched_line_decoder u_latched_line_decoder (
      .clk(clk), .rst(rst), .latch_en(latch_en), .en_n(en_n),
      .addr(addr), .sel_out(sel_out)
   );

   // {latch_en, en_n, addr, expected}, applied in order after reset (held address 0)
   localparam logic [21:0] VEC [0:7] = '{
      {1'b1, 1'b0, 4'h5, 16'h0020},
      {1'b0, 1'b0, 4'h9, 16'h0020},
      {1'b0, 1'b1, 4'h3, 16'h0000},
      {1'b0, 1'b0, 4'hC, 16'h0020},
      {1'b1, 1'b0, 4'hF, 16'h8000},
      {1'b1, 1'b1, 4'h2, 16'h0000},
      {1'b0, 1'b0, 4'h7, 16'h0004},
      {1'b1, 1'b0, 4'h8, 16'h0100}
   };

   task automatic chk(input string req, input logic [15:0] exp);
      checks++;
      if (sel_out !== exp) begin
         errors++;
         $display("FAIL %s: sel_out=%h expected=%h", req, sel_out, exp);
      end
      checks++;
      if (!$onehot0(sel_out)) begin
         errors++;
         $display("FAIL R2: sel_out=%h expected one-hot or zero", sel_out);
      end
   endtask

   // drive at negedge, let combinational path settle, model the next capture edge
   task automatic apply(input logic le, input logic en, input logic [3:0] a);
      @(negedge clk);
      latch_en = le; en_n = en; addr = a;
      #1;
   endtask

   function automatic logic [15:0] model(input logic le, input logic en, input logic [3:0] a);
      logic [3:0] eff;
      eff = le ? a : model_hold;
      return en ? 16'h0 : (16'h1 << eff);
   endfunction

   task automatic step(input string req, input logic le, input logic en, input logic [3:0] a);
      apply(le, en, a);
      chk(req, model(le, en, a));
      if (le) model_hold = a;
   endtask

   initial begin
      #(1_000_000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R6 reset state gated", 16'h0000);
      @(negedge clk); rst = 1'b0; en_n = 1'b0; #1;
      chk("R9 reset clears held address", 16'h0001);
      model_hold = 4'h0;

      // table walk
      foreach (VEC[i]) begin
         apply(VEC[i][21], VEC[i][20], VEC[i][19:16]);
         chk("R4/R5 table vector", VEC[i][15:0]);
      end
      model_hold = 4'h8;

      // all addresses, both latch states, both enable states (R1, R3, R5, R6)
      for (int a = 0; a < 16; a++) begin
         step("R1 live decode", 1'b1, 1'b0, 4'(a));
         step("R6 gated live", 1'b1, 1'b1, 4'(a));
         step("R3 hold after capture", 1'b0, 1'b0, 4'(15 - a));
         step("R6 gated hold", 1'b0, 1'b1, 4'(a ^ 5));
      end

      // R4: address changes ignored while holding
      step("R4 capture 0xA", 1'b1, 1'b0, 4'hA);
      for (int k = 0; k < 16; k++) step("R4 ignore address", 1'b0, 1'b0, 4'(k));

      // R7: enable activity and address motion while gated, latch falls with enable change
      step("R7 capture 0x6", 1'b1, 1'b1, 4'h6);
      for (int k = 0; k < 6; k++) step("R7 toggling enable", 1'b0, 1'(k & 1), 4'(k + 9));
      apply(1'b0, 1'b0, 4'h1);
      chk("R7 held address unchanged", 16'h0040);

      // R8: demultiplex a serial pattern onto line 0xD
      step("R8 select line 13", 1'b1, 1'b1, 4'hD);
      for (int k = 0; k < 8; k++) begin
         logic d;
         d = 1'((8'b1011_0010 >> k) & 1);
         apply(1'b0, ~d, 4'(k));
         chk("R8 demux data", d ? 16'h2000 : 16'h0000);
      end

      // R9: reset while holding clears the stored address
      step("R9 capture 0xE", 1'b1, 1'b0, 4'hE);
      @(negedge clk); latch_en = 1'b0; rst = 1'b1; addr = 4'h3;
      @(negedge clk); rst = 1'b0; en_n = 1'b0; #1;
      chk("R9 line 0 after reset", 16'h0001);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule